// File: doc/BRIEF.md
# Escape-Ring Slot Admission Checker

This block sits on one output link of a virtual cut-through torus router. It keeps a count, in whole packets, of the free slots in the two input queues on the far side of the link. One is the escape queue, which belongs to a deadlock-free dimension-ordered ring. The other is the adaptive queue. A request arrives for the packet at the head of a local input queue. It names the class and dimension of the queue the packet is in now, and the class and dimension of the queue it wants to enter. For each request the block gives back one combinational bit saying whether that hop is allowed.

Hops into the adaptive queue use plain cut-through: one free packet slot is enough. Hops into the escape queue need two free slots when the packet enters the ring from outside it. That covers injection, a change of dimension, and a move from an adaptive queue to an escape queue. This rule keeps at least one empty buffer in every unidirectional escape ring, and that empty buffer is what guarantees forward progress. A packet that is already travelling along the ring in the same dimension needs only one free slot. The counters are debited when the arbiter commits a packet to the link. They are credited when the neighbour returns a one-cycle pulse for a freed slot.

Top module: `ring_admit_ctrl`

## Requirements
- R1: After reset both slot counters hold full capacity, so every hop class into either queue is allowed.
- R2: With source class escape (code 1) and source dimension equal to target dimension, a hop into the escape queue (code 1) is allowed when at least one escape slot is free and refused at zero.
- R3: An injection (source class code 0) into the escape queue is allowed only when at least two escape slots are free.
- R4: A hop from an escape queue into the escape queue of a different dimension is allowed only when at least two escape slots are free.
- R5: A hop from an adaptive queue (code 2) into the escape queue needs at least two free escape slots, whether or not the dimensions match.
- R6: A hop into the adaptive queue (code 2) is allowed when at least one adaptive slot is free, whatever the source class, and the escape count has no effect on it.
- R7: A commit on a class (code 1 escape, code 2 adaptive) takes one slot from that class's counter. A credit pulse gives one slot back. A commit and a credit on the same counter in the same cycle leave the count unchanged. A commit naming class 0 or 3 changes nothing.
- R8: The counters saturate: a credit at full capacity and a commit at zero leave the count unchanged.
- R9: The permission output is combinational in the same cycle as the request. It is low when the request valid is low or when the target class is 0 or 3.
- R10: Queue capacity in packets is the queue depth in phits divided by the packet length in phits. With the defaults (80 phits, 20-phit packets) this gives 4 slots per queue, and an escape queue smaller than two packets is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_src_cls_i | input | 2 | Class of the current queue: 0 injection, 1 escape, 2 adaptive |
| req_src_dim_i | input | DIM_W | Dimension of the current queue |
| req_dst_cls_i | input | 2 | Class of the requested downstream queue: 1 escape, 2 adaptive |
| req_dst_dim_i | input | DIM_W | Dimension of the requested downstream queue |
| commit_i | input | 1 | One packet is committed to the link this cycle |
| commit_cls_i | input | 2 | Downstream queue class that the committed packet occupies |
| credit_esc_i | input | 1 | One-cycle pulse: the neighbour freed an escape slot |
| credit_adp_i | input | 1 | One-cycle pulse: the neighbour freed an adaptive slot |
| grant_ok_o | output | 1 | The requested hop is allowed |

## Verification
A slot count that drifts high would show at the ports as an injection allowed with only one escape slot left. That is the exact failure the two-slot rule exists to prevent, and it becomes visible on the first request after the faulty update. A count that drifts low, or that wraps at zero, shows instead as a same-dimension escape hop refused after one credit has returned, or as that hop allowed with no credit returned. Each counter is therefore walked through every threshold from full down to empty and back, and the request classes are probed at each step. Every update is followed by requests in the very next cycle, so an error appears within one clock of its cause.

// File: rtl/ring_admit_pkg.sv
package ring_admit_pkg;
  typedef enum logic [1:0] {
    CLS_INJ = 2'd0,
    CLS_ESC = 2'd1,
    CLS_ADP = 2'd2,
    CLS_RSV = 2'd3
  } q_cls_e;

  localparam int unsigned NUM_QKIND = 2;  // 0 escape, 1 adaptive

  function automatic q_cls_e kind_to_cls(input int unsigned k);
    return (k == 0) ? CLS_ESC : CLS_ADP;
  endfunction
endpackage

// File: rtl/slot_credit_ctr.sv
module slot_credit_ctr #(
  parameter int unsigned CAP = 4,
  parameter int unsigned W   = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] free_o
);
  localparam logic [W-1:0] CAP_W = W'(CAP);

  logic [W-1:0] free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= CAP_W;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (free_q < CAP_W) free_q <= free_q + W'(1);
        2'b01:   if (free_q != '0)   free_q <= free_q - W'(1);
        default: free_q <= free_q;  // idle, or a credit and a commit that cancel
      endcase
    end
  end

  assign free_o = free_q;

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= CAP_W);

  assert_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(free_q));

  assert_debit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && free_q != '0) |=> (free_q == $past(free_q) - W'(1)));

  assert_floor_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && free_q == '0) |=> (free_q == '0));
endmodule

// File: rtl/admit_rule.sv
module admit_rule
  import ring_admit_pkg::*;
#(
  parameter int unsigned DIM_W = 1,
  parameter int unsigned CW    = 3
) (
  input  logic             valid_i,
  input  q_cls_e           src_cls_i,
  input  logic [DIM_W-1:0] src_dim_i,
  input  q_cls_e           dst_cls_i,
  input  logic [DIM_W-1:0] dst_dim_i,
  input  logic [CW-1:0]    esc_free_i,
  input  logic [CW-1:0]    adp_free_i,
  output logic             ok_o
);
  logic in_ring;  // packet already travels this escape ring
  logic need_one_esc, need_two_esc, have_adp;

  assign in_ring      = (src_cls_i == CLS_ESC) && (src_dim_i == dst_dim_i);
  assign need_one_esc = esc_free_i >= CW'(1);
  assign need_two_esc = esc_free_i >= CW'(2);
  assign have_adp     = adp_free_i >= CW'(1);

  always_comb begin
    ok_o = 1'b0;
    if (valid_i) begin
      unique case (dst_cls_i)
        CLS_ESC: ok_o = in_ring ? need_one_esc : need_two_esc;
        CLS_ADP: ok_o = have_adp;
        default: ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ring_admit_ctrl.sv
module ring_admit_ctrl
  import ring_admit_pkg::*;
#(
  parameter int unsigned NUM_DIMS    = 2,
  parameter int unsigned PKT_PHITS   = 20,
  parameter int unsigned ESC_PHITS   = 80,
  parameter int unsigned ADP_PHITS   = 80,
  localparam int unsigned DIM_W      = (NUM_DIMS > 1) ? $clog2(NUM_DIMS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_src_cls_i,
  input  logic [DIM_W-1:0] req_src_dim_i,
  input  logic [1:0]       req_dst_cls_i,
  input  logic [DIM_W-1:0] req_dst_dim_i,
  input  logic             commit_i,
  input  logic [1:0]       commit_cls_i,
  input  logic             credit_esc_i,
  input  logic             credit_adp_i,
  output logic             grant_ok_o
);
  localparam int unsigned ESC_SLOTS = ESC_PHITS / PKT_PHITS;
  localparam int unsigned ADP_SLOTS = ADP_PHITS / PKT_PHITS;
  localparam int unsigned MAX_SLOTS = (ESC_SLOTS > ADP_SLOTS) ? ESC_SLOTS : ADP_SLOTS;
  localparam int unsigned CW        = $clog2(MAX_SLOTS + 1);

  if (ESC_SLOTS < 2) begin : g_bad_cap
    $error("escape queue must hold at least two packets (R10)");
  end

  logic [CW-1:0] free_w [NUM_QKIND];
  logic [NUM_QKIND-1:0] credit_w;

  assign credit_w = {credit_adp_i, credit_esc_i};

  for (genvar k = 0; k < NUM_QKIND; k++) begin : g_ctr
    localparam int unsigned CAP = (k == 0) ? ESC_SLOTS : ADP_SLOTS;
    logic dec;
    assign dec = commit_i && (q_cls_e'(commit_cls_i) == kind_to_cls(k));
    slot_credit_ctr #(.CAP(CAP), .W(CW)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (credit_w[k]),
      .dec_i  (dec),
      .free_o (free_w[k])
    );
  end

  admit_rule #(.DIM_W(DIM_W), .CW(CW)) u_rule (
    .valid_i    (req_valid_i),
    .src_cls_i  (q_cls_e'(req_src_cls_i)),
    .src_dim_i  (req_src_dim_i),
    .dst_cls_i  (q_cls_e'(req_dst_cls_i)),
    .dst_dim_i  (req_dst_dim_i),
    .esc_free_i (free_w[0]),
    .adp_free_i (free_w[1]),
    .ok_o       (grant_ok_o)
  );

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !grant_ok_o);

  assert_bubble_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_ok_o && req_dst_cls_i == 2'd1 && req_src_cls_i != 2'd1) |-> (free_w[0] >= CW'(2)));

  assert_ring_hop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_ok_o && req_dst_cls_i == 2'd1) |-> (free_w[0] != '0));

  assert_adp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_ok_o && req_dst_cls_i == 2'd2) |-> (free_w[1] != '0));
endmodule

// File: tb/tb_ring_admit_ctrl.sv
module tb_ring_admit_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] src_cls = 2'd0, dst_cls = 2'd0, cm_cls = 2'd0;
  logic src_dim = 1'b0, dst_dim = 1'b0;
  logic commit = 1'b0, cr_esc = 1'b0, cr_adp = 1'b0;
  logic grant;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  ring_admit_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_src_cls_i(src_cls), .req_src_dim_i(src_dim),
    .req_dst_cls_i(dst_cls), .req_dst_dim_i(dst_dim),
    .commit_i(commit), .commit_cls_i(cm_cls),
    .credit_esc_i(cr_esc), .credit_adp_i(cr_adp),
    .grant_ok_o(grant)
  );

  task automatic probe(input logic v, input logic [1:0] sc, input logic sd,
                       input logic [1:0] dc, input logic dd, input logic exp,
                       input string req);
    @(negedge clk);
    req_valid = v; src_cls = sc; src_dim = sd; dst_cls = dc; dst_dim = dd;
    #2;
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s: src=%0d/%0d dst=%0d/%0d got=%b exp=%b", req, sc, sd, dc, dd, grant, exp);
    end
    req_valid = 1'b0;
  endtask

  // one cycle of counter update; cls for commit, credit flags
  task automatic upd(input logic c, input logic [1:0] cls, input logic ce, input logic ca);
    @(negedge clk);
    commit = c; cm_cls = cls; cr_esc = ce; cr_adp = ca;
    @(negedge clk);
    commit = 1'b0; cr_esc = 1'b0; cr_adp = 1'b0;
  endtask

  task automatic t_reset;
    probe(1, 2'd0, 0, 2'd1, 0, 1, "R1 inject esc at reset");
    probe(1, 2'd2, 0, 2'd1, 1, 1, "R10 adp->esc at full 4 slots");
    probe(1, 2'd0, 0, 2'd2, 0, 1, "R1 inject adp at reset");
  endtask

  task automatic t_esc_drain;
    upd(1, 2'd1, 0, 0); upd(1, 2'd1, 0, 0);  // esc=2
    probe(1, 2'd0, 0, 2'd1, 0, 1, "R3 inject esc at 2");
    probe(1, 2'd1, 0, 2'd1, 1, 1, "R4 dim change at 2");
    upd(1, 2'd1, 0, 0);  // esc=1
    probe(1, 2'd0, 0, 2'd1, 0, 0, "R3 inject esc at 1");
    probe(1, 2'd1, 1, 2'd1, 1, 1, "R2 same dim at 1");
    probe(1, 2'd1, 0, 2'd1, 1, 0, "R4 dim change at 1");
    probe(1, 2'd2, 0, 2'd1, 0, 0, "R5 adp->esc same dim at 1");
    probe(1, 2'd2, 1, 2'd1, 0, 0, "R5 adp->esc other dim at 1");
    upd(1, 2'd1, 0, 0);  // esc=0
    probe(1, 2'd1, 0, 2'd1, 0, 0, "R2 same dim at 0");
    probe(1, 2'd1, 0, 2'd2, 0, 1, "R6 esc->adp unaffected by esc count");
  endtask

  task automatic t_cancel;  // esc=0 on entry
    upd(1, 2'd1, 1, 0);
    probe(1, 2'd1, 0, 2'd1, 0, 0, "R7 commit+credit leaves 0");
    upd(0, 2'd0, 1, 0);  // esc=1
    probe(1, 2'd1, 0, 2'd1, 0, 1, "R7 credit adds one");
    probe(1, 2'd0, 0, 2'd1, 0, 0, "R7 one slot not enough to inject");
    upd(1, 2'd0, 0, 0);  // commit class 0 ignored
    upd(1, 2'd3, 0, 0);  // commit class 3 ignored
    probe(1, 2'd1, 0, 2'd1, 0, 1, "R7 commit class 0/3 ignored");
  endtask

  task automatic t_adp;
    for (int i = 0; i < 4; i++) upd(1, 2'd2, 0, 0);  // adp=0
    probe(1, 2'd0, 0, 2'd2, 0, 0, "R6 inject adp at 0");
    probe(1, 2'd1, 1, 2'd2, 0, 0, "R6 esc->adp at 0");
    upd(0, 2'd0, 0, 1);
    probe(1, 2'd2, 0, 2'd2, 1, 1, "R6 adp->adp at 1");
  endtask

  task automatic t_sat;
    for (int i = 0; i < 10; i++) upd(0, 2'd0, 1, 0);
    for (int i = 0; i < 3; i++) upd(1, 2'd1, 0, 0);  // esc=1 if clamped at 4
    probe(1, 2'd0, 0, 2'd1, 0, 0, "R8 ceiling at capacity");
    probe(1, 2'd1, 0, 2'd1, 0, 1, "R8 one left after ceiling");
    for (int i = 0; i < 5; i++) upd(1, 2'd1, 0, 0);
    upd(0, 2'd0, 1, 0);  // esc=1 if floored at 0
    probe(1, 2'd1, 0, 2'd1, 0, 1, "R8 floor then credit same dim");
    probe(1, 2'd0, 0, 2'd1, 0, 0, "R8 floor then credit inject");
  endtask

  task automatic t_misc;
    for (int i = 0; i < 3; i++) upd(0, 2'd0, 1, 1);  // both full
    probe(0, 2'd0, 0, 2'd1, 0, 0, "R9 valid low");
    probe(1, 2'd0, 0, 2'd0, 0, 0, "R9 target class 0");
    probe(1, 2'd1, 0, 2'd3, 0, 0, "R9 target class 3");
    probe(1, 2'd0, 1, 2'd1, 1, 1, "R9 same-cycle grant");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_esc_drain();
    t_cancel();
    t_adp();
    t_sat();
    t_misc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule